// File: doc/BRIEF.md
# Write-and-Poll Sequencer for a Page-Programmed Parallel Memory

This block sits on the host side of a byte-wide parallel memory with internally timed writes. A single start pulse supplies a starting address, a byte count and a polling method. The engine then pulls bytes one per load from a data stream and issues them as write strobes. When a run of bytes crosses a page boundary, the engine cuts it into separate page loads. After each page it checks the device for completion instead of waiting out the worst-case programming time. It stops when the device reports ready, or when a cycle budget runs out.

Two completion checks are offered, and a mode input selects one.

- **Data polling:** the engine rereads the last address it wrote until the most significant data bit matches the byte it wrote there.
- **Toggle polling:** the engine watches the next-to-top bit across consecutive reads until two reads in a row agree.

Each page is followed by an enforced quiet gap before anything else touches the bus. The whole sequence is reported by a busy level and closes with either a done pulse or a timeout pulse. All bus strobes are active-low synchronous outputs, and the data bus has a separate drive enable.

Top module: `wpoll_engine`

## Requirements
- R1: Out of reset and whenever `busy` is low, all three strobes are high, `mem_dq_oe` is low, and `done`/`timeout` are low except for their single report pulse.
- R2: A start pulse is accepted only while idle and with a non-zero count. A start while busy, or with a count of zero, changes nothing on any output.
- R3: Each byte load takes three cycles: a setup cycle (chip select low, write strobe high, bus not driven), a strobe cycle (write strobe low), and a hold cycle (write strobe high). The data is driven in both the strobe and the hold cycle, and the read strobe stays high throughout.
- R4: All loads of one page share address bits [ADDR_W-1:PAGE_W]. When the next address would cross a 2^PAGE_W-byte boundary, the page is closed and polled, and the remaining bytes start as a new page.
- R5: With `cmd_toggle`=0, every poll reads the last address written. Completion is declared when read bit 7 equals bit 7 of the last byte written.
- R6: With `cmd_toggle`=1, completion is declared on the first read whose bit 6 equals bit 6 of the read just before it. A single read never completes.
- R7: A poll read holds chip select and read strobe low for two cycles with the write strobe high, samples on the second cycle, and is followed by one cycle with all strobes high.
- R8: The data bus is released for at least one cycle before the read strobe falls. The bus is never driven while the read strobe is low.
- R9: After a page completes, all strobes stay high for RECOVER_CYC cycles before the next load or before the command ends. `done` pulses for one cycle, in the first cycle after `busy` falls.
- R10: If a completion evaluation finds the device still busy and at least WC_MAX_CYC cycles have passed since the page's last hold cycle, polling stops. `timeout` pulses for one cycle, `busy` falls, the remaining bytes are dropped and no `done` is produced.
- R11: `dat_take` is high exactly in each setup cycle. The byte present on `dat_in` in that cycle is the one written.
- R12: Within a page, successive write strobes are three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle command pulse |
| cmd_addr | input | ADDR_W | First byte address |
| cmd_len | input | LEN_W | Number of bytes to write |
| cmd_toggle | input | 1 | 0: data polling, 1: toggle polling |
| dat_in | input | DATA_W | Next byte of the write stream |
| dat_take | output | 1 | Byte on `dat_in` is consumed this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: command completed |
| timeout | output | 1 | One-cycle pulse: write-cycle limit exceeded |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Write data |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Read data from the memory |

## Verification
The bench's device model stays busy for a set number of reads, so it covers several cases:

- **Fastest paths.** Zero-busy devices exercise the one-read data-poll finish and the two-read toggle finish. A toggle engine that trusted a single read would finish a read early.
- **Timeout boundary.** One device becomes ready exactly on the last evaluation allowed by the budget, and another never does. An off-by-one in the limit test turns the first into a timeout or lets the second run a read too long.
- **Page boundaries.** Runs start two bytes below a page edge, and a full aligned page is followed by a spill. An engine that split late would strobe across pages, and one that split early would poll mid-page; either breaks the cycle-exact trace.
- **Ignored commands.** Starts issued mid-command and with a zero count must leave the trace untouched.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN,
        ST_RD1,
        ST_RD2,
        ST_EVAL,
        ST_RECOVER
    } wp_state_e;
endpackage

// File: rtl/wpoll_count.sv
// Saturating cycle counter with synchronous clear.
module wpoll_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (en && !(&cnt_q))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/wpoll_addr_step.sv
// Next load address and page-end detection.
module wpoll_addr_step #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_next,
    output logic              page_last
);
    assign addr_next = addr_in + ADDR_W'(1);
    assign page_last = &addr_in[PAGE_W-1:0];
endmodule

// File: rtl/wpoll_eval.sv
// Completion decision for one sampled poll read.
module wpoll_eval (
    input  logic toggle_mode,
    input  logic smp_top,
    input  logic smp_tgl,
    input  logic ref_top,
    input  logic prev_tgl,
    input  logic have_prev,
    output logic complete
);
    always_comb begin
        if (toggle_mode)
            complete = have_prev && (smp_tgl == prev_tgl);
        else
            complete = (smp_top == ref_top);
    end
endmodule

// File: rtl/wpoll_engine.sv
module wpoll_engine
    import wpoll_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int LEN_W       = 16,
    parameter int WC_MAX_CYC  = 500000,
    parameter int RECOVER_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_toggle,
    input  logic [DATA_W-1:0] dat_in,
    output logic              dat_take,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int TOP_BIT = DATA_W - 1;
    localparam int TGL_BIT = DATA_W - 2;
    localparam int WCW     = $clog2(WC_MAX_CYC + 1) + 1;
    localparam int RCW     = $clog2(RECOVER_CYC + 1) + 1;
    localparam logic [WCW-1:0] WC_LIM   = WCW'(WC_MAX_CYC);
    localparam logic [RCW-1:0] REC_LAST = RCW'(RECOVER_CYC - 1);

    typedef struct packed {
        wp_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [DATA_W-1:0] wbyte;
        logic              tgl_mode;
        logic              smp_top;
        logic              smp_tgl;
        logic              prev_tgl;
        logic              have_prev;
        logic              done;
        logic              tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] addr_next;
    logic              page_last;
    logic              complete;
    logic [WCW-1:0]    wc_cnt;
    logic [RCW-1:0]    rec_cnt;
    logic              unused_rd_bits;

    assign unused_rd_bits = ^mem_dq_in[TGL_BIT-1:0];

    wpoll_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .addr_in   (ctl_q.addr),
        .addr_next (addr_next),
        .page_last (page_last)
    );

    wpoll_eval u_eval (
        .toggle_mode (ctl_q.tgl_mode),
        .smp_top     (ctl_q.smp_top),
        .smp_tgl     (ctl_q.smp_tgl),
        .ref_top     (ctl_q.wbyte[TOP_BIT]),
        .prev_tgl    (ctl_q.prev_tgl),
        .have_prev   (ctl_q.have_prev),
        .complete    (complete)
    );

    // Write-cycle budget: restarts on every hold cycle, runs while polling.
    wpoll_count #(.W(WCW)) u_wc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st == ST_HOLD),
        .en    (ctl_q.st != ST_IDLE),
        .count (wc_cnt)
    );

    // Quiet gap after a completed page.
    wpoll_count #(.W(RCW)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st != ST_RECOVER),
        .en    (ctl_q.st == ST_RECOVER),
        .count (rec_cnt)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.tmo  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_start && (cmd_len != '0)) begin
                    ctl_d.st       = ST_SETUP;
                    ctl_d.addr     = cmd_addr;
                    ctl_d.remain   = cmd_len;
                    ctl_d.tgl_mode = cmd_toggle;
                end
            end
            ST_SETUP: begin
                ctl_d.wbyte = dat_in;
                ctl_d.st    = ST_STROBE;
            end
            ST_STROBE: ctl_d.st = ST_HOLD;
            ST_HOLD: begin
                ctl_d.remain = ctl_q.remain - LEN_W'(1);
                if ((ctl_q.remain == LEN_W'(1)) || page_last) begin
                    ctl_d.st        = ST_TURN;
                    ctl_d.have_prev = 1'b0;
                end else begin
                    ctl_d.addr = addr_next;
                    ctl_d.st   = ST_SETUP;
                end
            end
            ST_TURN: ctl_d.st = ST_RD1;
            ST_RD1:  ctl_d.st = ST_RD2;
            ST_RD2: begin
                ctl_d.smp_top = mem_dq_in[TOP_BIT];
                ctl_d.smp_tgl = mem_dq_in[TGL_BIT];
                ctl_d.st      = ST_EVAL;
            end
            ST_EVAL: begin
                if (complete) begin
                    ctl_d.st = ST_RECOVER;
                end else if (wc_cnt >= WC_LIM) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.tmo = 1'b1;
                end else begin
                    ctl_d.prev_tgl  = ctl_q.smp_tgl;
                    ctl_d.have_prev = 1'b1;
                    ctl_d.st        = ST_RD1;
                end
            end
            ST_RECOVER: begin
                if (rec_cnt >= REC_LAST) begin
                    if (ctl_q.remain != '0) begin
                        ctl_d.addr = addr_next;
                        ctl_d.st   = ST_SETUP;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.st != ST_IDLE);
    assign done       = ctl_q.done;
    assign timeout    = ctl_q.tmo;
    assign dat_take   = (ctl_q.st == ST_SETUP);
    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.wbyte;
    assign mem_we_n   = (ctl_q.st != ST_STROBE);
    assign mem_oe_n   = !((ctl_q.st == ST_RD1) || (ctl_q.st == ST_RD2));
    assign mem_dq_oe  = (ctl_q.st == ST_STROBE) || (ctl_q.st == ST_HOLD);
    assign mem_ce_n   = !((ctl_q.st == ST_SETUP) || (ctl_q.st == ST_STROBE) ||
                          (ctl_q.st == ST_HOLD)  || (ctl_q.st == ST_RD1) ||
                          (ctl_q.st == ST_RD2));
endmodule

// File: rtl/wpoll_checker.sv
module wpoll_checker #(
    parameter int ADDR_W       = 15,
    parameter int PAGE_W       = 7,
    parameter int LOAD_GAP_MAX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic              dat_take,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic                     in_page_q;
    logic [ADDR_W-PAGE_W-1:0] pg_q;
    logic [7:0]               gap_q;
    logic                     unused_lo_addr;

    assign unused_lo_addr = ^mem_addr[PAGE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_page_q <= 1'b0;
            pg_q      <= '0;
            gap_q     <= '0;
        end else begin
            if (!busy || !mem_oe_n) begin
                in_page_q <= 1'b0;
            end else if (!mem_we_n) begin
                in_page_q <= 1'b1;
                pg_q      <= mem_addr[ADDR_W-1:PAGE_W];
            end
            if (!mem_we_n)         gap_q <= '0;
            else if (!(&gap_q))    gap_q <= gap_q + 8'd1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_accept_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));

    a_r3_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    a_r4_page_const: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && in_page_q) |-> (mem_addr[ADDR_W-1:PAGE_W] == pg_q));

    a_r7_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r8_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_dq_oe));

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    a_r11_take_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
        dat_take |-> (busy && !mem_ce_n && mem_we_n && !mem_dq_oe));

    a_r12_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && in_page_q) |-> (gap_q < 8'(LOAD_GAP_MAX)));
endmodule

bind wpoll_engine wpoll_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_wpoll_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .dat_take  (dat_take),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_wpoll_engine.sv
`timescale 1ns/1ps
module sim_wpoll_engine;
    localparam int AW  = 15;
    localparam int DW  = 8;
    localparam int LW  = 16;
    localparam int WC  = 30;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_toggle = 1'b0;
    logic [DW-1:0] dat_in = '0;
    logic          dat_take, busy, done, timeout;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    always #5 clk = ~clk;

    wpoll_engine #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_W(7), .LEN_W(LW),
        .WC_MAX_CYC(WC), .RECOVER_CYC(REC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_toggle(cmd_toggle), .dat_in(dat_in),
        .dat_take(dat_take), .busy(busy), .done(done), .timeout(timeout),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    typedef struct packed {
        logic          busy, ce_n, oe_n, we_n, dq_oe, take, done, tmo;
        logic [AW-1:0] addr;
        logic [DW-1:0] dq;
    } obs_t;

    obs_t   exq[$];
    string  tgq[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    string  idle_tag = "R1";
    logic [7:0] src [0:255];
    int     src_idx;
    bit     take_prev;
    // behavioural device model
    int     dev_k = 0;
    int     busy_left = 0;
    bit     last_d7 = 1'b0;
    bit     t6 = 1'b0;
    bit     rd_busy = 1'b0;
    bit     oe_prev_low = 1'b0;

    function automatic obs_t mk(bit b, bit ce, bit oe, bit we, bit doe, bit tk,
                                bit dn, bit to, int a, int d);
        obs_t o;
        o.busy = b; o.ce_n = ce; o.oe_n = oe; o.we_n = we; o.dq_oe = doe;
        o.take = tk; o.done = dn; o.tmo = to;
        o.addr = AW'(a); o.dq = DW'(d);
        return o;
    endfunction

    task automatic push(obs_t o, string t);
        exq.push_back(o);
        tgq.push_back(t);
    endtask

    task automatic build(int a0, int len, bit tog, int k);
        int a = a0;
        int left = len;
        int bi = 0;
        int last_a = a0;
        bit pg_end;
        int nread = tog ? ((k + 1 < 2) ? 2 : k + 1) : k + 1;
        int jt = (WC + 2) / 3;
        bit to = (nread > jt);
        if (to) nread = jt;
        while (left > 0) begin
            pg_end = 1'b0;
            while (left > 0 && !pg_end) begin
                push(mk(1,0,1,1,0,1,0,0,a,0), (a != a0 && a % 128 == 0) ? "R4 R11" : "R3 R11");
                push(mk(1,0,1,0,1,0,0,0,a,src[bi]), "R3 R12");
                push(mk(1,0,1,1,1,0,0,0,a,src[bi]), "R3");
                last_a = a;
                left--; bi++;
                pg_end = (a % 128 == 127);
                a = (a + 1) % 32768;
            end
            push(mk(1,1,1,1,0,0,0,0,0,0), "R8");
            for (int r = 0; r < nread; r++) begin
                push(mk(1,0,0,1,0,0,0,0,last_a,0), tog ? "R6 R7" : "R5 R7");
                push(mk(1,0,0,1,0,0,0,0,last_a,0), tog ? "R6 R7" : "R5 R7");
                push(mk(1,1,1,1,0,0,0,0,0,0), tog ? "R6" : "R5");
            end
            if (to) begin
                push(mk(0,1,1,1,0,0,0,1,0,0), "R10");
                return;
            end
            for (int r = 0; r < REC; r++) push(mk(1,1,1,1,0,0,0,0,0,0), "R9");
        end
        push(mk(0,1,1,1,0,0,1,0,0,0), "R9");
    endtask

    task automatic compare(obs_t e, string t);
        bit bad;
        obs_t g;
        g = mk(busy, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, dat_take, done, timeout,
               int'(mem_addr), int'(mem_dq_out));
        bad = (g.busy != e.busy) || (g.ce_n != e.ce_n) || (g.oe_n != e.oe_n) ||
              (g.we_n != e.we_n) || (g.dq_oe != e.dq_oe) || (g.take != e.take) ||
              (g.done != e.done) || (g.tmo != e.tmo);
        if (!e.ce_n && g.addr != e.addr) bad = 1'b1;
        if (e.dq_oe && g.dq != e.dq) bad = 1'b1;
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s t=%0t got %h expected %h", t, $time, g, e);
        end
    endtask

    task automatic step();
        obs_t e;
        string t;
        @(negedge clk);
        if (exq.size() > 0) begin
            e = exq.pop_front();
            t = tgq.pop_front();
        end else begin
            e = mk(0,1,1,1,0,0,0,0,0,0);
            t = idle_tag;
        end
        compare(e, t);
        // device: capture writes, answer reads
        if (!mem_we_n) begin
            last_d7   = mem_dq_out[7];
            busy_left = dev_k;
        end
        if (!mem_oe_n && !oe_prev_low) begin
            if (busy_left > 0) begin
                rd_busy = 1'b1;
                t6      = ~t6;
                busy_left--;
            end else begin
                rd_busy = 1'b0;
            end
        end
        oe_prev_low = !mem_oe_n;
        mem_dq_in = {rd_busy ? ~last_d7 : last_d7, t6, 6'h15};
        // data stream
        if (take_prev) src_idx++;
        dat_in    = src[src_idx % 256];
        take_prev = dat_take;
    endtask

    task automatic run_cmd(int a0, int len, bit tog, int k, int seed, int poke);
        for (int i = 0; i < 256; i++) src[i] = 8'((i * 37 + seed) ^ (i >> 1));
        src_idx   = 0;
        take_prev = 1'b0;
        dev_k     = k;
        step();
        build(a0, len, tog, k);
        cmd_addr = AW'(a0); cmd_len = LW'(len); cmd_toggle = tog; cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
        for (int c = 0; exq.size() > 0; c++) begin
            if (poke != 0 && c == poke) begin
                // R2: start while busy must be ignored
                cmd_addr = AW'(a0 + 300); cmd_len = LW'(3); cmd_toggle = ~tog;
                cmd_start = 1'b1;
            end else begin
                cmd_start = 1'b0;
            end
            step();
        end
        cmd_start = 1'b0;
        idle_tag = "R2";
        step(); step();
        idle_tag = "R1";
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        dat_in = src_default();
        repeat (3) @(posedge clk);
        step();               // R1 reset state
        rst_n = 1'b1;
        repeat (3) step();    // R1 idle after reset
        run_cmd(16'h0010, 1, 1'b0, 3, 1, 0);      // R5 data polling, busy reads
        run_cmd(16'h0200, 4, 1'b1, 2, 2, 5);      // R6 toggle, R2 poke while busy
        run_cmd(16'h007E, 5, 1'b0, 1, 3, 0);      // R4 page split
        run_cmd(16'h0033, 1, 1'b1, 0, 4, 0);      // R6 toggle needs two reads
        run_cmd(16'h0440, 2, 1'b0, 0, 5, 0);      // R5 first read already true
        run_cmd(16'h0500, 2, 1'b0, 100, 6, 0);    // R10 timeout
        run_cmd(16'h0600, 1, 1'b0, 9, 7, 0);      // R10 boundary: completes on last allowed read
        run_cmd(16'h0701, 3, 1'b1, 100, 8, 0);    // R10 timeout in toggle mode
        run_cmd(16'h0100, 130, 1'b1, 1, 9, 40);   // R4 full page plus spill, R12
        // R2: zero-length start is ignored
        step();
        idle_tag = "R2";
        cmd_addr = 15'h0123; cmd_len = '0; cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
        repeat (4) step();
        idle_tag = "R1";
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic [DW-1:0] src_default();
        return '0;
    endfunction
endmodule